// File: doc/BRIEF.md
# Bus Master Address Router

This block sits between a single bus master and the targets it talks to on a 16-bit address space: one RAM and a set of peripheral slaves. The most significant address bit splits the space into two halves. When it is clear, the RAM is the target. When it is set, the access is aimed at the peripheral half. In that half, the field just above the per-slave register bits holds a slave index.

For the chosen target, the block raises a select and hands over an address with the base removed. Only that target's acknowledge and read data are sent back to the master. An access that falls on an index beyond the last slave reaches no target. For such an access the router answers at once with an acknowledge and zero data, so the master never waits forever.

The router is purely combinational. It has two parameters: the number of slaves, and the number of register address bits given to each slave. Each slave therefore owns a window of two to the power of that width. With the defaults, there are four slaves of sixteen registers each, starting at 0x8000 and packed back to back.

Top module: `bus_addr_router`

## Requirements
- R1: With `m_req_i` high and address bit 15 clear, `ram_sel_o` is 1 and every bit of `slv_sel_o` is 0.
- R2: With `m_req_i` high, address bit 15 set, and index field k = address bits [14:SLV_AW] below NUM_SLAVES, only `slv_sel_o[k]` is 1 and `ram_sel_o` is 0. Slave k covers 0x8000 + k*2^SLV_AW up to the next window.
- R3: With `m_req_i` high, address bit 15 set, and an index field of NUM_SLAVES or more, no select is raised.
- R4: `ram_addr_o` equals address bits [14:0], and `slv_addr_o` equals address bits [SLV_AW-1:0].
- R5: `m_ack_o` equals the acknowledge of the selected target. Acknowledges from targets that are not selected have no effect on `m_ack_o`.
- R6: `m_rdata_o` equals the read data of the selected target. Read data from targets that are not selected has no effect on `m_rdata_o`.
- R7: An access with no target selected gets `m_ack_o` = 1 and `m_rdata_o` = 0 in the same cycle.
- R8: With `m_req_i` low, no select is raised, `m_ack_o` is 0 and `m_rdata_o` is 0, whatever the address and the slave responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_req_i | input | 1 | Master access request |
| m_addr_i | input | ADDR_W | Master byte/word address |
| m_ack_o | output | 1 | Acknowledge returned to the master |
| m_rdata_o | output | DATA_W | Read data returned to the master |
| ram_sel_o | output | 1 | RAM select |
| ram_addr_o | output | ADDR_W-1 | RAM local address |
| ram_ack_i | input | 1 | RAM acknowledge |
| ram_rdata_i | input | DATA_W | RAM read data |
| slv_sel_o | output | NUM_SLAVES | One select per peripheral slave |
| slv_addr_o | output | SLV_AW | Peripheral local register address |
| slv_ack_i | input | NUM_SLAVES | Peripheral acknowledges, one per slave |
| slv_rdata_i | input | NUM_SLAVES*DATA_W | Peripheral read data, slave k at bits [k*DATA_W +: DATA_W] |

## Verification
Every address of the lowest 256 peripheral addresses is swept. That covers each slave window, every register offset, and twelve unmapped index values, so a decoder that is off by one or that aliases indices is caught. RAM addresses and the top of the peripheral half are swept with a stride, so that a wrong local address or a leak of bit 15 shows up. For each address, the acknowledge pattern is varied across sources: the selected target is held low while the others are high, and the other way round. Each source also returns distinct read data. Together these separate correct routing from OR-ing of responses. A repeat of the sweep with the request low confirms that the router stays silent when idle.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_SLV  = 2'd2
  } tgt_e;
endpackage

// File: rtl/addr_router_decode.sv
module addr_router_decode #(
  parameter int NUM_SLAVES = 4,
  parameter int ADDR_W     = 16,
  parameter int SLV_AW     = 4,
  localparam int HI_W      = ADDR_W - SLV_AW,
  localparam int IDX_W     = ADDR_W - 1 - SLV_AW
) (
  input  logic                              req_i,
  input  logic [HI_W-1:0]                   addr_hi_i,
  output addr_router_pkg::tgt_e             tgt_o,
  output logic                              ram_hit_o,
  output logic [NUM_SLAVES-1:0]             slv_hit_o
);
  import addr_router_pkg::*;

  logic             periph;
  logic [IDX_W-1:0] idx;
  logic             mapped;

  assign periph = addr_hi_i[HI_W-1];
  assign idx    = addr_hi_i[IDX_W-1:0];

  // one comparator per slave window
  for (genvar k = 0; k < NUM_SLAVES; k++) begin : g_win
    assign slv_hit_o[k] = req_i && periph && (idx == IDX_W'(k));
  end

  assign ram_hit_o = req_i && !periph;
  assign mapped    = ram_hit_o || (|slv_hit_o);

  always_comb begin
    if (!req_i)         tgt_o = TGT_NONE;
    else if (ram_hit_o) tgt_o = TGT_RAM;
    else if (mapped)    tgt_o = TGT_SLV;
    else                tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/addr_router_resp_mux.sv
module addr_router_resp_mux #(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 16
) (
  input  logic                         req_i,
  input  addr_router_pkg::tgt_e        tgt_i,
  input  logic                         ram_hit_i,
  input  logic [NUM_SLAVES-1:0]        slv_hit_i,
  input  logic                         ram_ack_i,
  input  logic [DATA_W-1:0]            ram_rdata_i,
  input  logic [NUM_SLAVES-1:0]        slv_ack_i,
  input  logic [NUM_SLAVES*DATA_W-1:0] slv_rdata_i,
  output logic                         ack_o,
  output logic [DATA_W-1:0]            rdata_o
);
  import addr_router_pkg::*;

  logic [DATA_W-1:0] masked [NUM_SLAVES];
  logic [DATA_W-1:0] slv_data;
  logic              slv_ack;
  logic              unmapped;

  for (genvar k = 0; k < NUM_SLAVES; k++) begin : g_mask
    assign masked[k] = slv_rdata_i[k*DATA_W +: DATA_W] & {DATA_W{slv_hit_i[k]}};
  end

  // and-or tree; decoder guarantees at most one hit
  always_comb begin
    slv_data = '0;
    for (int k = 0; k < NUM_SLAVES; k++) slv_data |= masked[k];
  end

  assign slv_ack  = |(slv_ack_i & slv_hit_i);
  assign unmapped = req_i && (tgt_i == TGT_NONE);

  always_comb begin
    ack_o   = 1'b0;
    rdata_o = '0;
    if (ram_hit_i) begin
      ack_o   = ram_ack_i;
      rdata_o = ram_rdata_i;
    end else if (tgt_i == TGT_SLV) begin
      ack_o   = slv_ack;
      rdata_o = slv_data;
    end else if (unmapped) begin
      ack_o   = 1'b1;  // answer holes so the master cannot stall
    end
  end
endmodule

// File: rtl/bus_addr_router.sv
module bus_addr_router #(
  parameter int NUM_SLAVES = 4,
  parameter int SLV_AW     = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16
) (
  input  logic                         m_req_i,
  input  logic [ADDR_W-1:0]            m_addr_i,
  output logic                         m_ack_o,
  output logic [DATA_W-1:0]            m_rdata_o,
  output logic                         ram_sel_o,
  output logic [ADDR_W-2:0]            ram_addr_o,
  input  logic                         ram_ack_i,
  input  logic [DATA_W-1:0]            ram_rdata_i,
  output logic [NUM_SLAVES-1:0]        slv_sel_o,
  output logic [SLV_AW-1:0]            slv_addr_o,
  input  logic [NUM_SLAVES-1:0]        slv_ack_i,
  input  logic [NUM_SLAVES*DATA_W-1:0] slv_rdata_i
);
  import addr_router_pkg::*;

  localparam int HI_W = ADDR_W - SLV_AW;

  tgt_e                  tgt;
  logic                  ram_hit;
  logic [NUM_SLAVES-1:0] slv_hit;

  addr_router_decode #(
    .NUM_SLAVES(NUM_SLAVES),
    .ADDR_W    (ADDR_W),
    .SLV_AW    (SLV_AW)
  ) u_dec (
    .req_i    (m_req_i),
    .addr_hi_i(m_addr_i[ADDR_W-1 -: HI_W]),
    .tgt_o    (tgt),
    .ram_hit_o(ram_hit),
    .slv_hit_o(slv_hit)
  );

  addr_router_resp_mux #(
    .NUM_SLAVES(NUM_SLAVES),
    .DATA_W    (DATA_W)
  ) u_mux (
    .req_i      (m_req_i),
    .tgt_i      (tgt),
    .ram_hit_i  (ram_hit),
    .slv_hit_i  (slv_hit),
    .ram_ack_i  (ram_ack_i),
    .ram_rdata_i(ram_rdata_i),
    .slv_ack_i  (slv_ack_i),
    .slv_rdata_i(slv_rdata_i),
    .ack_o      (m_ack_o),
    .rdata_o    (m_rdata_o)
  );

  assign ram_sel_o  = ram_hit;
  assign slv_sel_o  = slv_hit;
  // zero-referenced local addresses
  assign ram_addr_o = m_addr_i[ADDR_W-2:0];
  assign slv_addr_o = m_addr_i[SLV_AW-1:0];
endmodule

// File: rtl/bus_addr_router_chk.sv
module bus_addr_router_chk #(
  parameter int NUM_SLAVES = 4,
  parameter int SLV_AW     = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16
) (
  input logic                  m_req_i,
  input logic [ADDR_W-1:0]     m_addr_i,
  input logic                  m_ack_o,
  input logic [DATA_W-1:0]     m_rdata_o,
  input logic                  ram_sel_o,
  input logic                  ram_ack_i,
  input logic [NUM_SLAVES-1:0] slv_sel_o
);
  localparam int IDX_W = ADDR_W - 1 - SLV_AW;

  logic [IDX_W-1:0] idx;
  logic             hole;

  assign idx  = m_addr_i[ADDR_W-2:SLV_AW];
  assign hole = m_req_i && m_addr_i[ADDR_W-1] && (int'(idx) >= NUM_SLAVES);

  always_comb begin
    // R1
    if (ram_sel_o) ram_excl_chk: assert (slv_sel_o == '0 && m_req_i && !m_addr_i[ADDR_W-1]);
    // R2
    sel_onehot_chk: assert ($onehot0(slv_sel_o));
    // R3
    if (hole) hole_nosel_chk: assert (!ram_sel_o && slv_sel_o == '0);
    // R5
    if (ram_sel_o) ram_ack_route_chk: assert (m_ack_o == ram_ack_i);
    // R7
    if (hole) hole_answer_chk: assert (m_ack_o && m_rdata_o == '0);
    // R8
    if (!m_req_i) idle_quiet_chk: assert (!ram_sel_o && slv_sel_o == '0 && !m_ack_o && m_rdata_o == '0);
  end
endmodule

bind bus_addr_router bus_addr_router_chk #(
  .NUM_SLAVES(NUM_SLAVES),
  .SLV_AW    (SLV_AW),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .m_req_i  (m_req_i),
  .m_addr_i (m_addr_i),
  .m_ack_o  (m_ack_o),
  .m_rdata_o(m_rdata_o),
  .ram_sel_o(ram_sel_o),
  .ram_ack_i(ram_ack_i),
  .slv_sel_o(slv_sel_o)
);

// File: tb/bus_addr_router_test.sv
module bus_addr_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              m_req;
  logic [15:0]       m_addr;
  logic              m_ack;
  logic [DW-1:0]     m_rdata;
  logic              ram_sel;
  logic [14:0]       ram_addr;
  logic              ram_ack;
  logic [DW-1:0]     ram_rdata;
  logic [NS-1:0]     slv_sel;
  logic [AW-1:0]     slv_addr;
  logic [NS-1:0]     slv_ack;
  logic [NS*DW-1:0]  slv_rdata;

  bus_addr_router #(.NUM_SLAVES(NS), .SLV_AW(AW), .ADDR_W(16), .DATA_W(DW)) uut (
    .m_req_i(m_req), .m_addr_i(m_addr), .m_ack_o(m_ack), .m_rdata_o(m_rdata),
    .ram_sel_o(ram_sel), .ram_addr_o(ram_addr), .ram_ack_i(ram_ack), .ram_rdata_i(ram_rdata),
    .slv_sel_o(slv_sel), .slv_addr_o(slv_addr), .slv_ack_i(slv_ack), .slv_rdata_i(slv_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s addr=%h req=%0b act=%h exp=%h", tag, m_addr, m_req, act, exp);
    end
  endtask

  // one vector: drive after negedge, settle, compare
  task automatic apply(bit req, int a, int ackpat);
    int idx;
    int tgt;  // 0 none, 1 ram, 2 slave
    int e_ack, e_rd, e_sel;
    @(negedge clk);
    m_req   = req;
    m_addr  = 16'(a);
    ram_ack = ackpat[NS];
    slv_ack = NS'(ackpat);
    ram_rdata = 16'(16'hA000 ^ a);
    for (int k = 0; k < NS; k++) slv_rdata[k*DW +: DW] = 16'((16'h1100 * (k + 1)) ^ a ^ 16'h0F0F);
    #(CLK_PERIOD/4);
    idx = (a >> AW) & 16'h7FF;
    if (!req) tgt = 0;
    else if (!a[15]) tgt = 1;
    else if (idx < NS) tgt = 2;
    else tgt = 0;
    e_sel = (tgt == 2) ? (1 << idx) : 0;
    case (tgt)
      1: begin e_ack = ackpat[NS]; e_rd = (16'hA000 ^ a) & 16'hFFFF; end
      2: begin e_ack = (ackpat >> idx) & 1; e_rd = ((16'h1100 * (idx + 1)) ^ a ^ 16'h0F0F) & 16'hFFFF; end
      default: begin e_ack = req ? 1 : 0; e_rd = 0; end
    endcase
    if (!req) begin
      check("R8 idle ram_sel", int'(ram_sel), 0);
      check("R8 idle slv_sel", int'(slv_sel), 0);
      check("R8 idle ack", int'(m_ack), 0);
      check("R8 idle rdata", int'(m_rdata), 0);
    end else if (tgt == 1) begin
      check("R1 ram_sel", int'(ram_sel), 1);
      check("R1 slv_sel", int'(slv_sel), 0);
      check("R5 ram ack", int'(m_ack), e_ack);
      check("R6 ram rdata", int'(m_rdata), e_rd);
    end else if (tgt == 2) begin
      check("R2 slv_sel", int'(slv_sel), e_sel);
      check("R2 ram_sel", int'(ram_sel), 0);
      check("R5 slv ack", int'(m_ack), e_ack);
      check("R6 slv rdata", int'(m_rdata), e_rd);
    end else begin
      check("R3 hole ram_sel", int'(ram_sel), 0);
      check("R3 hole slv_sel", int'(slv_sel), 0);
      check("R7 hole ack", int'(m_ack), 1);
      check("R7 hole rdata", int'(m_rdata), 0);
    end
    check("R4 ram_addr", int'(ram_addr), a & 16'h7FFF);
    check("R4 slv_addr", int'(slv_addr), a & ((1 << AW) - 1));
  endtask

  task automatic sweep_addr(bit req, int a);
    int idx;
    idx = (a >> AW) & 16'h7FF;
    // selected low, others high; then selected high, others low
    if (!a[15]) begin
      apply(req, a, 32'h0F);
      apply(req, a, 32'h10);
    end else if (idx < NS) begin
      apply(req, a, 32'h1F ^ (1 << idx));
      apply(req, a, 1 << idx);
    end else begin
      apply(req, a, 32'h1F);
      apply(req, a, 32'h00);
    end
  endtask

  initial begin
    m_req = 0; m_addr = '0; ram_ack = 0; ram_rdata = '0; slv_ack = '0; slv_rdata = '0;
    #(CLK_PERIOD/4);
    check("R8 reset ack", int'(m_ack), 0);
    check("R8 reset sel", int'(slv_sel) | int'(ram_sel), 0);
    // R2 R3: every window, offset and low hole index
    for (int a = 16'h8000; a < 16'h8100; a++) sweep_addr(1, a);
    // R1 R4: strided RAM sweep including both ends
    for (int a = 0; a < 32768; a += 257) sweep_addr(1, a);
    sweep_addr(1, 16'h7FFF);
    // R3 R7: top of peripheral half
    for (int a = 16'hFF00; a < 65536; a += 17) sweep_addr(1, a);
    sweep_addr(1, 16'hFFFF);
    // R8: idle sweep
    for (int a = 0; a < 65536; a += 311) sweep_addr(0, a);
    for (int a = 16'h8000; a < 16'h8040; a++) sweep_addr(0, a);
    done = 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      done = 1;
    end
  end

  initial begin
    wait (done);
    #(CLK_PERIOD);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule